// File: doc/BRIEF.md
# Strict-Priority Block Transmit Drain

This block empties four transmit queues, each made of 32-bit descriptors with one 32-byte data block per descriptor, into a byte-wide transmit FIFO. Between frames it looks at all queues. A queue holds work when the producer's write pointer differs from the engine's read pointer, and the lowest-numbered such queue wins. The engine then fetches the first descriptor of that queue, which carries the frame length and the source port.

The data is streamed in three phases. The first phase covers block zero, the middle phase covers the inner blocks, and the last phase covers the final block, which may be partly filled. Every byte moves only when the FIFO has room. A 4-byte Ethernet CRC-32 follows the data. The engine then waits for an end-of-frame pulse from the transmitter. On that pulse it moves the queue's read pointer past every descriptor of the frame and drops its busy indication in the same clock edge.

Descriptors are addressed by byte pointer. The buffer block of the descriptor at pointer p starts at byte (p/4)*32 of the data RAM. Both RAM read ports return data one clock after the request. The pointers advance linearly modulo 2^PTR_W.

Top module: `prio_tx_drain`

## Requirements
- R1: During and right after reset, `active_o` and `fifo_wr_o` are 0. The read pointer of queue q equals q*(2^PTR_W/NQ), which is 1024*q with the defaults.
- R2: A queue is non-empty exactly when its write pointer differs from its read pointer. While all queues are empty, no frame starts, no FIFO write occurs and no read pointer moves.
- R3: When a frame starts, `cur_q_o` is the lowest-indexed non-empty queue, because queue 0 has the highest priority.
- R4: The selected queue stays fixed from frame start until the read-pointer update. A higher-priority queue that fills mid-frame is served only after the current frame completes, and the current frame's bytes stay intact.
- R5: The first descriptor carries the frame length L (1 to 2047) in bits 28:18 and the port in bits 17:16. `frame_port_o` shows that port while the frame's bytes are sent.
- R6: Byte i of a frame is read from data address (ptr/4)*32 + i, where ptr is the read pointer. The L data bytes reach the FIFO in increasing order of i.
- R7: `phase_o` encodes 0 for idle, 1 for the first block, 2 for a middle block and 3 for the last block, the CRC and the end-of-frame wait. With n = ceil(L/32), the bytes of block 0 show 1 and the bytes of block n-1 (when n>1) show 3. A frame with L<=32 never shows 2. Exactly L-32*(n-1) bytes are sent in the final block.
- R8: `fifo_wr_o` is never asserted while `fifo_full_i` is 1.
- R9: After the data, the engine writes four bytes of CRC-32 over the data: reflected polynomial 0xEDB88320, initial value all ones, final inversion, least significant byte first. The frame is L+4 bytes in total.
- R10: After the CRC, the engine writes nothing and keeps the read pointers unchanged until `eof_i` is sampled high. On that edge the selected queue's read pointer increases by 4*n.
- R11: `active_o` is 1 from the cycle after selection until the edge that updates the read pointer, and it is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_ptr_i | input | NQ*PTR_W | Producer write pointers, queue q in slice q |
| rd_ptr_o | output | NQ*PTR_W | Engine read pointers, queue q in slice q |
| desc_rd_o | output | 1 | Descriptor read request |
| desc_addr_o | output | PTR_W | Descriptor byte address |
| desc_data_i | input | 32 | Descriptor word, one cycle after request |
| buf_rd_o | output | 1 | Data RAM read request |
| buf_addr_o | output | PTR_W+3 | Data RAM byte address |
| buf_data_i | input | 8 | Data byte, one cycle after request |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 8 | FIFO write byte |
| fifo_full_i | input | 1 | FIFO has no room |
| eof_i | input | 1 | Transmitter end-of-frame pulse |
| active_o | output | 1 | Frame in progress |
| cur_q_o | output | $clog2(NQ) | Queue being served |
| frame_port_o | output | 2 | Port field of the current frame |
| phase_o | output | 2 | Block phase of the current frame |

## Verification
Directed single frames of length 1, 32, 33, 64 and 100 separate three cases: a frame of one block, a frame whose final block is full, and a frame with a partial final block. They also separate frames that have middle blocks from those that have none, which exposes errors in the block count and the pointer step.

Loading all four queues in the same cycle, with low-priority queues filled first, shows whether selection follows priority or arrival order. Adding a queue-0 frame while a long queue-3 frame is in flight shows whether the scan runs again in mid-frame.

A random mix of lengths, ports, queues and FIFO drain rates stresses pacing on FIFO space and the ordering of the pointer update. Every frame's bytes and CRC are compared with values computed in the bench.

// File: rtl/prio_tx_drain.sv
module prio_tx_drain #(
  parameter int NQ    = 4,
  parameter int PTR_W = 12,
  parameter int LEN_W = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NQ*PTR_W-1:0]   wr_ptr_i,
  output logic [NQ*PTR_W-1:0]   rd_ptr_o,
  output logic                  desc_rd_o,
  output logic [PTR_W-1:0]      desc_addr_o,
  input  logic [31:0]           desc_data_i,
  output logic                  buf_rd_o,
  output logic [PTR_W+2:0]      buf_addr_o,
  input  logic [7:0]            buf_data_i,
  output logic                  fifo_wr_o,
  output logic [7:0]            fifo_data_o,
  input  logic                  fifo_full_i,
  input  logic                  eof_i,
  output logic                  active_o,
  output logic [$clog2(NQ)-1:0] cur_q_o,
  output logic [1:0]            frame_port_o,
  output logic [1:0]            phase_o
);
  localparam int QW    = $clog2(NQ);
  localparam int BUF_W = PTR_W + 3;
  localparam int BLK_W = LEN_W - 4;
  localparam int QSPAN = (1 << PTR_W) / NQ;

  typedef enum logic [2:0] {S_IDLE, S_DESC, S_LOAD, S_FETCH, S_PUSH, S_CRC, S_EOF} st_t;

  st_t              st;
  logic [PTR_W-1:0] rd_q [NQ];
  logic [NQ-1:0]    nonempty;
  logic [QW-1:0]    pick, q_sel;
  logic [LEN_W-1:0] len, idx;
  logic [BLK_W-1:0] nblk;
  logic [31:0]      crc;
  logic [1:0]       cidx, port;
  logic [LEN_W:0]   len_sum;
  logic [BLK_W-1:0] blk;
  logic [31:0]      crc_fin;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] x;
    x = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) x = x[0] ? ((x >> 1) ^ 32'hEDB88320) : (x >> 1);
    return x;
  endfunction

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign nonempty[q] = wr_ptr_i[q*PTR_W +: PTR_W] != rd_q[q];
    assign rd_ptr_o[q*PTR_W +: PTR_W] = rd_q[q];
  end

  always_comb begin
    pick = '0;
    for (int q = NQ - 1; q >= 0; q--) if (nonempty[q]) pick = QW'(q);
  end

  assign len_sum      = {1'b0, desc_data_i[18 +: LEN_W]} + (LEN_W+1)'(31);
  assign blk          = BLK_W'(idx[LEN_W-1:5]);
  assign crc_fin      = ~crc;
  assign active_o     = st != S_IDLE;
  assign cur_q_o      = q_sel;
  assign frame_port_o = port;
  assign desc_rd_o    = st == S_DESC;
  assign desc_addr_o  = rd_q[q_sel];
  assign buf_rd_o     = st == S_FETCH && !fifo_full_i;
  assign buf_addr_o   = {rd_q[q_sel][PTR_W-1:2], 5'b0} + BUF_W'(idx);
  assign fifo_wr_o    = st == S_PUSH || (st == S_CRC && !fifo_full_i);
  assign fifo_data_o  = st == S_CRC ? crc_fin[8*cidx +: 8] : buf_data_i;

  always_comb begin
    if (st == S_IDLE)                       phase_o = 2'd0;
    else if (st == S_DESC || st == S_LOAD)  phase_o = 2'd1;
    else if (st == S_CRC || st == S_EOF)    phase_o = 2'd3;
    else if (blk == '0)                     phase_o = 2'd1;
    else if (blk == nblk - BLK_W'(1))       phase_o = 2'd3;
    else                                    phase_o = 2'd2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      q_sel <= '0;
      len   <= '0;
      idx   <= '0;
      nblk  <= '0;
      crc   <= '1;
      cidx  <= '0;
      port  <= '0;
      for (int q = 0; q < NQ; q++) rd_q[q] <= PTR_W'(q * QSPAN);
    end else begin
      case (st)
        S_IDLE: if (|nonempty) begin
          q_sel <= pick;
          st    <= S_DESC;
        end
        S_DESC: st <= S_LOAD;
        S_LOAD: begin
          len  <= desc_data_i[18 +: LEN_W];
          port <= desc_data_i[17:16];
          nblk <= len_sum[LEN_W:5];
          idx  <= '0;
          crc  <= '1;
          st   <= S_FETCH;
        end
        S_FETCH: if (!fifo_full_i) st <= S_PUSH;
        S_PUSH: begin
          crc <= crc_step(crc, buf_data_i);
          if (idx == len - LEN_W'(1)) begin
            cidx <= '0;
            st   <= S_CRC;
          end else begin
            idx <= idx + LEN_W'(1);
            st  <= S_FETCH;
          end
        end
        S_CRC: if (!fifo_full_i) begin
          cidx <= cidx + 2'd1;
          if (cidx == 2'd3) st <= S_EOF;
        end
        S_EOF: if (eof_i) begin
          rd_q[q_sel] <= rd_q[q_sel] + PTR_W'({nblk, 2'b00});
          st          <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  fifo_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_o |-> !fifo_full_i);
  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !eof_i) |=> $stable(rd_ptr_o));
  // R2
  idle_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |=> $stable(rd_ptr_o));
  // R3
  prio_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> (($past(nonempty) & ((NQ'(1) << cur_q_o) - NQ'(1))) == '0));
  // R4
  q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |=> (!active_o || $stable(cur_q_o)));
endmodule

// File: tb/prio_tx_drain_bench.sv
module prio_tx_drain_bench;
  localparam int NQ = 4, PTR_W = 12, LEN_W = 11, FDEPTH = 8;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [NQ*PTR_W-1:0] wr_ptr_i, rd_ptr_o;
  logic desc_rd_o, buf_rd_o, fifo_wr_o, fifo_full_i, active_o;
  logic eof_i = 0;
  logic [PTR_W-1:0] desc_addr_o;
  logic [31:0] desc_data_i;
  logic [PTR_W+2:0] buf_addr_o;
  logic [7:0] buf_data_i, fifo_data_o;
  logic [1:0] cur_q_o, frame_port_o, phase_o;

  prio_tx_drain #(.NQ(NQ), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_prio_tx_drain (
    .clk, .rst_n, .wr_ptr_i, .rd_ptr_o, .desc_rd_o, .desc_addr_o, .desc_data_i,
    .buf_rd_o, .buf_addr_o, .buf_data_i, .fifo_wr_o, .fifo_data_o, .fifo_full_i,
    .eof_i, .active_o, .cur_q_o, .frame_port_o, .phase_o);

  logic [31:0] dmem [1024];
  logic [7:0]  bmem [32768];
  logic [7:0]  cap  [32768];
  int cap_n = 0, fcnt = 0, drain_pct = 100, full_viol = 0;
  int total = 0, fails = 0, enq_n = 0, done_n = 0;
  int wr [NQ];
  int head [NQ], tail [NQ];
  int flen [NQ][64], fport [NQ][64], fseed [NQ][64];
  logic [NQ-1:0] snap = '0;

  always_comb for (int q = 0; q < NQ; q++) wr_ptr_i[q*PTR_W +: PTR_W] = PTR_W'(wr[q]);
  assign fifo_full_i = fcnt == FDEPTH;

  always @(posedge clk) begin
    if (desc_rd_o) desc_data_i <= dmem[desc_addr_o >> 2];
    if (buf_rd_o)  buf_data_i  <= bmem[buf_addr_o];
  end

  always @(posedge clk) begin
    bit dr;
    dr = fcnt > 0 && (($urandom % 100) < drain_pct);
    if (fifo_wr_o && fcnt == FDEPTH) full_viol++;
    fcnt <= fcnt + int'(fifo_wr_o) - int'(dr);
    if (fifo_wr_o) begin
      cap[cap_n] <= fifo_data_o;
      cap_n <= cap_n + 1;
    end
    for (int q = 0; q < NQ; q++) snap[q] <= (tail[q] - head[q]) > 0;
  end

  function automatic logic [7:0] gbyte(int seed, int i);
    return 8'(seed * 53 + i * 29 + (i >> 4));
  endfunction

  function automatic logic [31:0] crc_ref(logic [31:0] c, logic [7:0] d);
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ d[b]) c = (c >> 1) ^ 32'hEDB88320;
      else c = c >> 1;
    end
    return c;
  endfunction

  function automatic int exp_phase(int i, int L);
    int n = (L + 31) / 32;
    if (i >= L) return 3;
    if (i / 32 == 0) return 1;
    if (i / 32 == n - 1) return 3;
    return 2;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic enq(int q, int L, int port);
    int ptr = wr[q];
    int n = (L + 31) / 32;
    int seed = enq_n * 7 + q;
    int k = tail[q];
    dmem[(ptr >> 2) & 1023] = {3'b0, 11'(L), 2'(port), 16'h0};
    for (int b = 1; b < n; b++) dmem[((ptr >> 2) + b) & 1023] = 32'h0;
    for (int i = 0; i < L; i++) bmem[(((ptr >> 2) & 1023) * 32 + i) & 32767] = gbyte(seed, i);
    flen[q][k] = L; fport[q][k] = port; fseed[q][k] = seed;
    tail[q]++;
    enq_n++;
    wr[q] = (ptr + 4 * n) & 4095;
  endtask

  task automatic handle_frame();
    int q = -1, k, L, n, s, bad, pbad, qbad, old;
    logic [31:0] c;
    for (int i = NQ - 1; i >= 0; i--) if (snap[i]) q = i;
    chk(q >= 0 && cur_q_o == 2'(q), "R3", "selected queue", cur_q_o, q);
    if (q < 0) q = cur_q_o;
    k = head[q]; L = flen[q][k]; n = (L + 31) / 32; s = cap_n;
    old = int'(rd_ptr_o[q*PTR_W +: PTR_W]);
    pbad = 0; qbad = 0;
    while (cap_n < s + L + 4) begin
      if (fifo_wr_o && phase_o != 2'(exp_phase(cap_n - s, L))) pbad++;
      if (cur_q_o != 2'(q) || !active_o) qbad++;
      @(negedge clk);
    end
    chk(qbad == 0, "R4", "queue held during frame", qbad, 0);
    chk(pbad == 0, "R7", "block phase per byte", pbad, 0);
    chk(frame_port_o == 2'(fport[q][k]), "R5", "port field", frame_port_o, fport[q][k]);
    chk(int'(rd_ptr_o[q*PTR_W +: PTR_W]) == old, "R10", "pointer before eof", rd_ptr_o[q*PTR_W +: PTR_W], old);
    bad = 0; c = 32'hFFFFFFFF;
    for (int i = 0; i < L; i++) begin
      if (cap[s + i] != gbyte(fseed[q][k], i)) bad++;
      c = crc_ref(c, gbyte(fseed[q][k], i));
    end
    chk(bad == 0, L <= 32 ? "R7" : "R6", "data bytes", bad, 0);
    c = ~c;
    chk({cap[s+L+3], cap[s+L+2], cap[s+L+1], cap[s+L]} == c, "R9", "crc bytes",
        {cap[s+L+3], cap[s+L+2], cap[s+L+1], cap[s+L]}, c);
    repeat (3) @(negedge clk);
    chk(cap_n == s + L + 4, "R10", "no writes awaiting eof", cap_n - s, L + 4);
    chk(active_o == 1'b1, "R11", "active until eof", active_o, 1);
    eof_i = 1;
    @(negedge clk);
    eof_i = 0;
    chk(active_o == 1'b0, "R11", "active cleared by eof", active_o, 0);
    chk(int'(rd_ptr_o[q*PTR_W +: PTR_W]) == ((old + 4 * n) & 4095), "R10", "pointer step",
        rd_ptr_o[q*PTR_W +: PTR_W], (old + 4 * n) & 4095);
    head[q]++;
    done_n++;
  endtask

  initial begin
    bit was = 0;
    forever begin
      @(negedge clk);
      if (rst_n && active_o && !was) handle_frame();
      was = active_o;
    end
  end

  task automatic wait_done();
    while (done_n < enq_n) @(negedge clk);
  endtask

  task automatic at_drive();
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "R11", "watchdog expired", done_n, enq_n);
    summary();
  end

  initial begin
    logic [31:0] c;
    void'($urandom(32'd4242));
    for (int q = 0; q < NQ; q++) begin
      wr[q] = q * 1024; head[q] = 0; tail[q] = 0;
    end
    repeat (3) @(negedge clk);
    chk(active_o == 0 && fifo_wr_o == 0, "R1", "outputs in reset", {active_o, fifo_wr_o}, 0);
    rst_n = 1;
    @(negedge clk);
    for (int q = 0; q < NQ; q++)
      chk(int'(rd_ptr_o[q*PTR_W +: PTR_W]) == q * 1024, "R1", "reset pointer", rd_ptr_o[q*PTR_W +: PTR_W], q * 1024);
    chk(active_o == 0, "R1", "idle after reset", active_o, 0);

    begin
      int act = 0;
      repeat (20) begin @(negedge clk); if (active_o) act++; end
      chk(act == 0 && cap_n == 0, "R2", "empty queues stay idle", act + cap_n, 0);
    end

    c = 32'hFFFFFFFF;
    for (int i = 0; i < 9; i++) c = crc_ref(c, 8'h31 + 8'(i));
    chk(~c == 32'hCBF43926, "R9", "bench crc anchor", ~c, 32'hCBF43926);

    foreach (flen[0][i]) if (i < 5) begin
      int lens [5] = '{1, 32, 33, 64, 100};
      at_drive(); enq(1, lens[i], i & 3); wait_done();
    end

    drain_pct = 40;
    at_drive();
    enq(3, 40, 3); enq(2, 20, 2); enq(1, 70, 1); enq(0, 5, 0); enq(0, 33, 1);
    wait_done();

    at_drive(); enq(3, 200, 2);
    while (!active_o) @(negedge clk);
    at_drive(); enq(0, 10, 1);
    wait_done();

    for (int r = 0; r < 30; r++) begin
      drain_pct = 30 + int'($urandom % 70);
      at_drive();
      enq(int'($urandom % 4), 1 + int'($urandom % 300), int'($urandom % 4));
      repeat (int'($urandom % 400)) @(posedge clk);
    end
    wait_done();
    @(negedge clk);
    chk(full_viol == 0, "R8", "writes while full", full_viol, 0);
    summary();
  end
endmodule